// File: doc/BRIEF.md
# Keyed Configuration Register Port

The block gives a host a byte-wide doorway into the setup of a peripheral I/O controller. Two adjacent I/O addresses are decoded. The lower one is an index port and the upper one is a data port. After reset the doorway is closed. Writing one specific key byte to the index port opens it. While it is open, the index port picks one of sixteen configuration registers and the data port reads or writes the register picked. Writing an exit byte to the index port closes the doorway again.

The register contents drive the controller's wiring directly. Bits in the registers enable the disk interface, the floppy controller, two serial ports and a parallel port, and they select a legacy base address for each. A parameter selects the alternate chip variant, which changes both the key byte and the identity byte. Bus timing is a single-cycle synchronous write strobe. Read data is combinational while the read strobe is high.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked and the index is 0. Register 0x0 holds 0x11 and every other writable register holds 0x00. As a result the disk and floppy enables are 1 at bases 0x1F0 and 0x3F0, and both serial ports and the parallel port are disabled.
- R2: While locked, an index-port write of the key byte (0x55, or 0x44 when ALT_VARIANT=1) unlocks the port. Any other byte written to the index port leaves the port locked and leaves the index unchanged.
- R3: While locked, data-port writes leave every register unchanged, and reads of either port return 0xFF.
- R4: While unlocked, an index-port write of any byte other than 0xAA loads the low 4 bits of that byte into the index. An index-port read returns the index zero-extended to 8 bits.
- R5: While unlocked, an index-port write of 0xAA locks the port.
- R6: While unlocked, a data-port write to registers 0x0 through 0xA stores the byte, and a data-port read returns it.
- R7: Register 0xD reads 0x65 (0x66 when ALT_VARIANT=1). Register 0xE reads the REVISION parameter (default 0x01). Writes to either register have no effect.
- R8: Registers 0xB, 0xC and 0xF read 0x00, and writes to them have no effect.
- R9: Register 0x0 bit 0 drives the disk interface enable, and bit 4 drives the floppy enable.
- R10: Register 0x5 bit 0 moves the floppy base from 0x3F0 to 0x370. Bit 1 moves the disk base from 0x1F0 to 0x170.
- R11: In register 0x2, bits 1:0 select the serial 1 base and bit 2 enables serial 1. Bits 5:4 select the serial 2 base and bit 6 enables serial 2. Select codes 0, 1, 2 and 3 map to bases 0x3F8, 0x2F8, 0x338 and 0x238.
- R12: Register 0x1 bits 1:0 set the parallel port. Code 0 disables it and gives base 0x000. Codes 1, 2 and 3 enable it at 0x3BC, 0x378 and 0x278.
- R13: Writes to any address other than 0x3F0 and 0x3F1 change nothing, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| unlocked | output | 1 | Configuration access is open |
| ide_en | output | 1 | Disk interface enable |
| ide_base | output | 10 | Disk interface base address |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 10 | Floppy controller base address |
| ser1_en | output | 1 | Serial port 1 enable |
| ser1_base | output | 10 | Serial port 1 base address |
| ser2_en | output | 1 | Serial port 2 enable |
| ser2_base | output | 10 | Serial port 2 base address |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 10 | Parallel port base address |

## Verification
The unlock machine is driven with three kinds of index byte while locked: the real key, the other variant's key, and the exit byte. Only the first may open the port. Data writes made while locked are read back after unlocking, which shows that they were dropped rather than held. Every select code of both serial fields and of the parallel field is swept, and register values are written to the index and data ports at neighbouring addresses. These patterns separate a wrong mapping table, swapped fields and a loose address decode.

// File: rtl/keyed_cfg_port_pkg.sv
package keyed_cfg_port_pkg;
  localparam int BASE_W = 10;
  localparam logic [7:0] EXIT_BYTE = 8'hAA;

  function automatic logic [BASE_W-1:0] serial_base(input logic [1:0] sel);
    case (sel)
      2'd0:    return 10'h3F8;
      2'd1:    return 10'h2F8;
      2'd2:    return 10'h338;
      default: return 10'h238;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] lpt_base(input logic [1:0] sel);
    case (sel)
      2'd1:    return 10'h3BC;
      2'd2:    return 10'h378;
      2'd3:    return 10'h278;
      default: return 10'h000;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h11 : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_lock_ctl.sv
module cfg_lock_ctl #(
  parameter logic [7:0] KEY = 8'h55,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [7:0]       wdata,
  output logic             unlocked,
  output logic [IDX_W-1:0] index
);
  import keyed_cfg_port_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      index    <= '0;
    end else if (idx_wr) begin
      if (!unlocked) begin
        if (wdata == KEY) unlocked <= 1'b1;
      end else if (wdata == EXIT_BYTE) begin
        unlocked <= 1'b0;
      end else begin
        index <= wdata[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int NREG = 16,
  parameter int FIRST_RSVD = 11,
  parameter int ID_IDX = 13,
  parameter int REV_IDX = 14,
  parameter logic [7:0] CHIP_ID = 8'h65,
  parameter logic [7:0] REVISION = 8'h01,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  index,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_val,
  output logic [NREG*8-1:0] reg_flat
);
  import keyed_cfg_port_pkg::*;

  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i < FIRST_RSVD) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= reg_default(i);
        else if (wr_en && index == IDX_W'(i)) regs[i] <= wdata;
      end
    end else begin : g_rsvd
      assign regs[i] = 8'h00;
    end
    assign reg_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    if (index == IDX_W'(ID_IDX))       rd_val = CHIP_ID;
    else if (index == IDX_W'(REV_IDX)) rd_val = REVISION;
    else                               rd_val = regs[index];
  end
endmodule

// File: rtl/cfg_map.sv
module cfg_map
  import keyed_cfg_port_pkg::*;
(
  input  logic              ide_on,
  input  logic              fdc_on,
  input  logic              ide_alt,
  input  logic              fdc_alt,
  input  logic [6:0]        ser_cfg,
  input  logic [1:0]        par_cfg,
  output logic              ide_en,
  output logic [BASE_W-1:0] ide_base,
  output logic              fdc_en,
  output logic [BASE_W-1:0] fdc_base,
  output logic              ser1_en,
  output logic [BASE_W-1:0] ser1_base,
  output logic              ser2_en,
  output logic [BASE_W-1:0] ser2_base,
  output logic              par_en,
  output logic [BASE_W-1:0] par_base
);
  logic unused_gap;
  assign unused_gap = ser_cfg[3];

  assign ide_en    = ide_on;
  assign fdc_en    = fdc_on;
  assign ide_base  = ide_alt ? 10'h170 : 10'h1F0;
  assign fdc_base  = fdc_alt ? 10'h370 : 10'h3F0;
  assign ser1_en   = ser_cfg[2];
  assign ser1_base = serial_base(ser_cfg[1:0]);
  assign ser2_en   = ser_cfg[6];
  assign ser2_base = serial_base(ser_cfg[5:4]);
  assign par_en    = (par_cfg != 2'd0);
  assign par_base  = lpt_base(par_cfg);
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 10'h3F0,
  parameter bit ALT_VARIANT = 1'b0,
  parameter logic [7:0] REVISION = 8'h01,
  parameter int NREG = 16,
  parameter int FIRST_RSVD = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              unlocked,
  output logic              ide_en,
  output logic [9:0]        ide_base,
  output logic              fdc_en,
  output logic [9:0]        fdc_base,
  output logic              ser1_en,
  output logic [9:0]        ser1_base,
  output logic              ser2_en,
  output logic [9:0]        ser2_base,
  output logic              par_en,
  output logic [9:0]        par_base
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [7:0] KEY = ALT_VARIANT ? 8'h44 : 8'h55;
  localparam logic [7:0] CHIP_ID = ALT_VARIANT ? 8'h66 : 8'h65;
  localparam logic [ADDR_W-1:0] DATA_ADDR = INDEX_ADDR + 1'b1;

  logic             hit_idx, hit_dat, idx_wr, dat_wr;
  logic [IDX_W-1:0] index;
  logic [7:0]       rd_val;
  logic [NREG*8-1:0] reg_flat;

  assign hit_idx = (io_addr == INDEX_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);
  assign idx_wr  = io_wr && hit_idx;
  assign dat_wr  = io_wr && hit_dat && unlocked;

  cfg_lock_ctl #(.KEY(KEY), .IDX_W(IDX_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .unlocked(unlocked), .index(index)
  );

  cfg_regbank #(
    .NREG(NREG), .FIRST_RSVD(FIRST_RSVD), .ID_IDX(NREG-3), .REV_IDX(NREG-2),
    .CHIP_ID(CHIP_ID), .REVISION(REVISION)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .index(index), .wdata(io_wdata),
    .rd_val(rd_val), .reg_flat(reg_flat)
  );

  cfg_map u_map (
    .ide_on(reg_flat[0]), .fdc_on(reg_flat[4]),
    .ide_alt(reg_flat[5*8+1]), .fdc_alt(reg_flat[5*8]),
    .ser_cfg(reg_flat[2*8 +: 7]), .par_cfg(reg_flat[1*8 +: 2]),
    .ide_en(ide_en), .ide_base(ide_base), .fdc_en(fdc_en), .fdc_base(fdc_base),
    .ser1_en(ser1_en), .ser1_base(ser1_base), .ser2_en(ser2_en), .ser2_base(ser2_base),
    .par_en(par_en), .par_base(par_base)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit_idx)      io_rdata = unlocked ? {{(8-IDX_W){1'b0}}, index} : 8'hFF;
    else if (io_rd && hit_dat) io_rdata = unlocked ? rd_val : 8'hFF;
  end
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 10'h3F0,
  parameter logic [7:0] KEY = 8'h55,
  parameter int IDX_W = 4,
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              unlocked,
  input logic [IDX_W-1:0]  index,
  input logic [NREG*8-1:0] reg_flat,
  input logic              par_en,
  input logic [9:0]        par_base
);
  logic at_idx, at_dat;
  assign at_idx = (io_addr == INDEX_ADDR);
  assign at_dat = (io_addr == INDEX_ADDR + 1'b1);

  // R2
  key_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && at_idx && io_wdata != KEY) |=> (!unlocked && $stable(index)));
  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && at_idx && io_wdata == KEY) |=> unlocked);
  // R3
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(reg_flat));
  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_rd && (at_idx || at_dat)) |-> io_rdata == 8'hFF);
  // R4
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && at_idx && io_wdata != 8'hAA) |=> index == $past(io_wdata[IDX_W-1:0]));
  // R5
  exit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && at_idx && io_wdata == 8'hAA) |=> !unlocked);
  // R12
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_en == (par_base != 10'h000));
  // R13
  stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !at_idx && !at_dat) |=> ($stable(unlocked) && $stable(index) && $stable(reg_flat)));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .KEY(KEY), .IDX_W(IDX_W), .NREG(NREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked), .index(index),
  .reg_flat(reg_flat), .par_en(par_en), .par_base(par_base)
);

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = 10'h000;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       unlocked, ide_en, fdc_en, ser1_en, ser2_en, par_en;
  logic [9:0] ide_base, fdc_base, ser1_base, ser2_base, par_base;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [9:0] IDX = 10'h3F0, DAT = 10'h3F1;

  always #4 clk = ~clk;

  keyed_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked),
    .ide_en(ide_en), .ide_base(ide_base), .fdc_en(fdc_en), .fdc_base(fdc_base),
    .ser1_en(ser1_en), .ser1_base(ser1_base), .ser2_en(ser2_en), .ser2_base(ser2_base),
    .par_en(par_en), .par_base(par_base)
  );

  function automatic logic [9:0] com_addr(input int code);
    logic [9:0] t [4] = '{10'h3F8, 10'h2F8, 10'h338, 10'h238};
    return t[code];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    wr(IDX, i); wr(DAT, v);
  endtask

  task automatic expect_reg(input string req, input logic [7:0] i, input logic [7:0] v);
    logic [7:0] d;
    wr(IDX, i); rd(DAT, d); check(req, d, v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 locked", unlocked, 0);
    check("R1 ide", {ide_en, ide_base}, {1'b1, 10'h1F0});
    check("R1 fdc", {fdc_en, fdc_base}, {1'b1, 10'h3F0});
    check("R1 serial off", {ser1_en, ser2_en}, 0);
    check("R1 par off", {par_en, par_base}, 0);
    rd(IDX, d); check("R3 locked idx read", d, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    wr(IDX, 8'h44); check("R2 wrong key", unlocked, 0);
    wr(IDX, 8'hAA); check("R2 exit while locked", unlocked, 0);
    wr(IDX, 8'h03);
    wr(DAT, 8'h00); wr(DAT, 8'h77);
    rd(DAT, d); check("R3 locked data read", d, 8'hFF);
    wr(IDX, 8'h55); check("R2 key opens", unlocked, 1);
    rd(IDX, d); check("R2 index kept 0", d, 8'h00);
    expect_reg("R3 reg0 untouched", 8'h00, 8'h11);
  endtask

  task automatic t_rw();
    logic [7:0] d;
    wr(IDX, 8'h37); rd(IDX, d); check("R4 index low nibble", d, 8'h07);
    set_reg(8'h03, 8'hA5); expect_reg("R6 reg3", 8'h03, 8'hA5);
    set_reg(8'h0A, 8'h3C); expect_reg("R6 regA", 8'h0A, 8'h3C);
    set_reg(8'h07, 8'hAA); expect_reg("R6 reg7 exit byte as data", 8'h07, 8'hAA);
  endtask

  task automatic t_ro();
    expect_reg("R7 id", 8'h0D, 8'h65);
    set_reg(8'h0D, 8'h00); expect_reg("R7 id after write", 8'h0D, 8'h65);
    set_reg(8'h0E, 8'hFF); expect_reg("R7 revision", 8'h0E, 8'h01);
    set_reg(8'h0B, 8'hFF); expect_reg("R8 regB", 8'h0B, 8'h00);
    set_reg(8'h0C, 8'h5A); expect_reg("R8 regC", 8'h0C, 8'h00);
    set_reg(8'h0F, 8'hFF); expect_reg("R8 regF", 8'h0F, 8'h00);
  endtask

  task automatic t_map();
    set_reg(8'h00, 8'h01); check("R9 ide on fdc off", {ide_en, fdc_en}, 2'b10);
    set_reg(8'h00, 8'h10); check("R9 ide off fdc on", {ide_en, fdc_en}, 2'b01);
    set_reg(8'h05, 8'h01); check("R10 fdc alt", {fdc_base, ide_base}, {10'h370, 10'h1F0});
    set_reg(8'h05, 8'h02); check("R10 ide alt", {fdc_base, ide_base}, {10'h3F0, 10'h170});
    for (int s = 0; s < 4; s++) begin
      set_reg(8'h02, {1'b0, 1'b1, 2'(3 - s), 1'b0, 1'b0, 2'(s)});
      check("R11 ser1", {ser1_en, ser1_base}, {1'b0, com_addr(s)});
      check("R11 ser2", {ser2_en, ser2_base}, {1'b1, com_addr(3 - s)});
    end
    set_reg(8'h02, 8'h04); check("R11 ser1 enable only", {ser1_en, ser2_en}, 2'b10);
    for (int p = 0; p < 4; p++) begin
      logic [9:0] e;
      e = (p == 0) ? 10'h000 : (p == 1) ? 10'h3BC : (p == 2) ? 10'h378 : 10'h278;
      set_reg(8'h01, 8'(p));
      check("R12 par", {par_en, par_base}, {p != 0, e});
    end
  endtask

  task automatic t_stray();
    logic [7:0] d;
    wr(IDX, 8'h03);
    wr(10'h3F2, 8'hAA); check("R13 stray exit", unlocked, 1);
    wr(10'h3EF, 8'h09);
    wr(10'h2F1, 8'h00);
    rd(IDX, d); check("R13 index kept", d, 8'h03);
    rd(DAT, d); check("R13 reg3 kept", d, 8'hA5);
    rd(10'h3F2, d); check("R13 stray read", d, 8'h00);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    wr(IDX, 8'h0A);
    wr(IDX, 8'hAA); check("R5 exit locks", unlocked, 0);
    rd(DAT, d); check("R5 data read locked", d, 8'hFF);
    wr(DAT, 8'h00);
    wr(IDX, 8'h55);
    rd(IDX, d); check("R5 index kept over lock", d, 8'h0A);
    rd(DAT, d); check("R3 regA untouched", d, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_rw();
    t_ro();
    t_map();
    t_stray();
    t_exit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule